// File: doc/BRIEF.md
# Serial-PHY Link Training Controller

This block sequences link bring-up for a packet protocol carried over a serial PHY that has a low-speed PWM mode and a high-speed burst mode. After reset it waits in Detect with only lane 0 running at low speed. Discovery and configuration also run over lane 0 only. When configuration finishes, the lanes that were chosen switch to high-speed burst and the link enters L0. From L0 the controller can go to the low-power states, to Recovery for retraining or a bandwidth change, or to one of three states set by the data link layer: Disabled, Hot-Reset or Loopback.

Every state is registered. The per-lane PHY mode requests and the link-up flag are decoded from the current state, from the lane set captured at the end of configuration, and from the live transmit-idle input. Lanes left unused by configuration are kept in hibernate. In L0 a lane whose transmitter is idle stalls instead of sending electrical idle.

Top module: `link_train_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no stimulus, state_o is 0 (Detect), link_up_o is 0 and lane_mode_o has lane 0 at code 1 (PWM low speed) with every other lane at code 0 (hibernate). Lane k's 2-bit mode sits at lane_mode_o[2k+1:2k].
- R2: State codes on state_o are: Detect 0, Configuration 1, L0 2, L1 3, L2 4, Recovery 5, Disabled 6, Hot-Reset 7, Loopback 8. In Detect, peer_det_i moves the machine to Configuration on the next clock.
- R3: In Configuration, lane 0 stays at code 1 and the other lanes stay at code 0. cfg_fail_i returns the machine to Detect, and this takes precedence over cfg_done_i. cfg_done_i moves it to L0 and captures the lane set as lane_req_i with lane 0 always included. The captured set goes back to lane 0 alone whenever the machine is in Detect.
- R4: In L0 each configured lane reports code 2 (high-speed burst), or code 3 (stall) while tx_idle_i is high. Unconfigured lanes report code 0.
- R5: L0 exits in this priority order: link_err_i or retrain_i to Recovery, then enter_l2_i to L2, then enter_l1_i to L1.
- R6: In L1, L2 and Disabled all lanes report code 0. wake_i moves L1 to Recovery and moves L2 to Detect.
- R7: In Recovery, configured lanes report code 2. recov_done_i returns the machine to L0. If RECOV_TIMEOUT cycles pass in Recovery without recov_done_i, it falls back to Detect. recov_done_i on the last of those cycles still wins.
- R8: In Configuration, L0 and Recovery, a directive outranks every other input. dir_disable_i leads to Disabled, otherwise dir_hot_reset_i leads to Hot-Reset, otherwise dir_loopback_i leads to Loopback.
- R9: Disabled, Hot-Reset and Loopback each move to Detect on the clock after their own directive drops. In Hot-Reset and Loopback the lanes in the captured set report code 2.
- R10: link_up_o is high exactly in L0, L1 and Recovery. These states are reachable only through a successful Configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| peer_det_i | input | 1 | Link partner detected |
| cfg_done_i | input | 1 | Configuration completed |
| cfg_fail_i | input | 1 | Configuration failed |
| lane_req_i | input | NUM_LANES | Lanes chosen by configuration |
| link_err_i | input | 1 | Transient link error in L0 |
| retrain_i | input | 1 | Retrain or bandwidth change request |
| enter_l1_i | input | 1 | Request to enter L1 |
| enter_l2_i | input | 1 | Request to enter L2 |
| wake_i | input | 1 | Wake from L1 or L2 |
| recov_done_i | input | 1 | Recovery completed |
| tx_idle_i | input | 1 | Transmitter has nothing to send |
| dir_disable_i | input | 1 | Data link layer directive: disable |
| dir_hot_reset_i | input | 1 | Data link layer directive: hot reset |
| dir_loopback_i | input | 1 | Data link layer directive: loopback |
| state_o | output | 4 | Current state code |
| lane_mode_o | output | 2*NUM_LANES | Per-lane PHY mode request |
| link_up_o | output | 1 | Link trained and usable |

## Verification
A state change is due one clock after the input that causes it. lane_mode_o and link_up_o follow the new state in that same cycle, because they are decoded from it without another register. The stall code is the only exception: it tracks tx_idle_i within the current cycle. The bench therefore drives each input set 1 ns after a rising edge and compares all three outputs 1 ns after the next rising edge. The Recovery timeout is checked by holding the machine for RECOV_TIMEOUT-1 clocks, confirming it has not left, and then checking the exit on the following edge. An asynchronous reset is checked 1 ns after rst_ni falls, with no edge in between.

// File: rtl/link_train_pkg.sv
package link_train_pkg;

  typedef enum logic [3:0] {
    ST_DETECT   = 4'd0,
    ST_CFG      = 4'd1,
    ST_L0       = 4'd2,
    ST_L1       = 4'd3,
    ST_L2       = 4'd4,
    ST_RECOV    = 4'd5,
    ST_DISABLED = 4'd6,
    ST_HOTRST   = 4'd7,
    ST_LOOPBK   = 4'd8
  } lt_state_e;

  typedef enum logic [1:0] {
    LM_HIBERN   = 2'd0,
    LM_PWM_LS   = 2'd1,
    LM_HS_BURST = 2'd2,
    LM_STALL    = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic disable_req;
    logic hot_reset;
    logic loopback;
  } lt_dir_t;

  function automatic logic link_is_up(lt_state_e s);
    return (s == ST_L0) || (s == ST_L1) || (s == ST_RECOV);
  endfunction

  function automatic logic dir_allowed(lt_state_e s);
    return (s == ST_CFG) || (s == ST_L0) || (s == ST_RECOV);
  endfunction

endpackage

// File: rtl/lt_timeout_ctr.sv
module lt_timeout_ctr #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (!expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);

  // R7: the window restarts on every Recovery entry
  a_r7_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  a_r7_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/lt_state_ctrl.sv
module lt_state_ctrl
  import link_train_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 peer_det_i,
  input  logic                 cfg_done_i,
  input  logic                 cfg_fail_i,
  input  logic [NUM_LANES-1:0] lane_req_i,
  input  logic                 link_err_i,
  input  logic                 retrain_i,
  input  logic                 enter_l1_i,
  input  logic                 enter_l2_i,
  input  logic                 wake_i,
  input  logic                 recov_done_i,
  input  lt_dir_t              dir_i,
  input  logic                 recov_expired_i,
  output lt_state_e            state_o,
  output logic [NUM_LANES-1:0] lane_mask_o
);
  localparam logic [NUM_LANES-1:0] LANE0_ONLY = NUM_LANES'(1);

  lt_state_e st_q, st_d;
  lt_state_e dir_tgt;
  logic      dir_any;
  logic [NUM_LANES-1:0] mask_q;

  assign dir_any = dir_i.disable_req | dir_i.hot_reset | dir_i.loopback;

  always_comb begin
    if (dir_i.disable_req)    dir_tgt = ST_DISABLED;
    else if (dir_i.hot_reset) dir_tgt = ST_HOTRST;
    else                      dir_tgt = ST_LOOPBK;
  end

  always_comb begin
    st_d = st_q;
    if (dir_allowed(st_q) && dir_any) begin
      st_d = dir_tgt;
    end else begin
      unique case (st_q)
        ST_DETECT:   if (peer_det_i) st_d = ST_CFG;
        ST_CFG: begin
          if (cfg_fail_i)      st_d = ST_DETECT;
          else if (cfg_done_i) st_d = ST_L0;
        end
        ST_L0: begin
          if (link_err_i || retrain_i) st_d = ST_RECOV;
          else if (enter_l2_i)         st_d = ST_L2;
          else if (enter_l1_i)         st_d = ST_L1;
        end
        ST_L1:       if (wake_i) st_d = ST_RECOV;
        ST_L2:       if (wake_i) st_d = ST_DETECT;
        ST_RECOV: begin
          if (recov_done_i)         st_d = ST_L0;
          else if (recov_expired_i) st_d = ST_DETECT;
        end
        ST_DISABLED: if (!dir_i.disable_req) st_d = ST_DETECT;
        ST_HOTRST:   if (!dir_i.hot_reset)   st_d = ST_DETECT;
        ST_LOOPBK:   if (!dir_i.loopback)    st_d = ST_DETECT;
        default:     st_d = ST_DETECT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_DETECT;
    else         st_q <= st_d;
  end

  // captured lane set; lane 0 is always part of the link
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mask_q <= LANE0_ONLY;
    else if (st_q == ST_DETECT)              mask_q <= LANE0_ONLY;
    else if (st_q == ST_CFG && st_d == ST_L0) mask_q <= lane_req_i | LANE0_ONLY;
  end

  assign state_o     = st_q;
  assign lane_mask_o = mask_q;

  a_r3_l0_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_L0 && $past(st_q) == ST_CFG) |-> $past(cfg_done_i));
  a_r6_l1_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_L1 && wake_i) |=> (st_q == ST_RECOV));
  a_r8_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_allowed(st_q) && dir_i.disable_req) |=> (st_q == ST_DISABLED));
  a_r9_disabled_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DISABLED && !dir_i.disable_req) |=> (st_q == ST_DETECT));
  a_r3_mask_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_L0) |-> mask_q[0]);

endmodule

// File: rtl/lt_lane_map.sv
module lt_lane_map
  import link_train_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input  lt_state_e              state_i,
  input  logic [NUM_LANES-1:0]   lane_mask_i,
  input  logic                   tx_idle_i,
  output logic [2*NUM_LANES-1:0] lane_mode_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_mode_e m;
    always_comb begin
      m = LM_HIBERN;
      unique case (state_i)
        ST_DETECT, ST_CFG: m = (g == 0) ? LM_PWM_LS : LM_HIBERN;
        ST_L0:             if (lane_mask_i[g]) m = tx_idle_i ? LM_STALL : LM_HS_BURST;
        ST_RECOV, ST_HOTRST, ST_LOOPBK:
                           if (lane_mask_i[g]) m = LM_HS_BURST;
        default:           m = LM_HIBERN;
      endcase
    end
    assign lane_mode_o[2*g +: 2] = m;
  end
endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
  import link_train_pkg::*;
#(
  parameter int unsigned NUM_LANES     = 4,
  parameter int unsigned RECOV_TIMEOUT = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   peer_det_i,
  input  logic                   cfg_done_i,
  input  logic                   cfg_fail_i,
  input  logic [NUM_LANES-1:0]   lane_req_i,
  input  logic                   link_err_i,
  input  logic                   retrain_i,
  input  logic                   enter_l1_i,
  input  logic                   enter_l2_i,
  input  logic                   wake_i,
  input  logic                   recov_done_i,
  input  logic                   tx_idle_i,
  input  logic                   dir_disable_i,
  input  logic                   dir_hot_reset_i,
  input  logic                   dir_loopback_i,
  output logic [3:0]             state_o,
  output logic [2*NUM_LANES-1:0] lane_mode_o,
  output logic                   link_up_o
);
  lt_state_e            state;
  logic [NUM_LANES-1:0] lane_mask;
  logic                 recov_expired;
  lt_dir_t              dir;

  assign dir = '{disable_req: dir_disable_i, hot_reset: dir_hot_reset_i,
                 loopback: dir_loopback_i};

  lt_timeout_ctr #(.LIMIT(RECOV_TIMEOUT)) u_recov_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state == ST_RECOV),
    .expired_o (recov_expired)
  );

  lt_state_ctrl #(.NUM_LANES(NUM_LANES)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .peer_det_i      (peer_det_i),
    .cfg_done_i      (cfg_done_i),
    .cfg_fail_i      (cfg_fail_i),
    .lane_req_i      (lane_req_i),
    .link_err_i      (link_err_i),
    .retrain_i       (retrain_i),
    .enter_l1_i      (enter_l1_i),
    .enter_l2_i      (enter_l2_i),
    .wake_i          (wake_i),
    .recov_done_i    (recov_done_i),
    .dir_i           (dir),
    .recov_expired_i (recov_expired),
    .state_o         (state),
    .lane_mask_o     (lane_mask)
  );

  lt_lane_map #(.NUM_LANES(NUM_LANES)) u_map (
    .state_i     (state),
    .lane_mask_i (lane_mask),
    .tx_idle_i   (tx_idle_i),
    .lane_mode_o (lane_mode_o)
  );

  assign state_o   = state;
  assign link_up_o = link_is_up(state);

  a_r7_recov_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RECOV && recov_expired && !recov_done_i &&
     !dir_disable_i && !dir_hot_reset_i && !dir_loopback_i) |=> (state_o == 4'd0));
  a_r10_up_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |-> (state_o == 4'd2 || state_o == 4'd3 || state_o == 4'd5));
  a_r4_stall_only_idle_l0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_mode_o[1:0] == 2'd3) |-> (state_o == 4'd2 && tx_idle_i));
  a_r2_lane0_low_speed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 4'd1) |-> (lane_mode_o[1:0] == 2'd1));

endmodule

// File: tb/sim_link_train_ctrl.sv
module sim_link_train_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int RT = 16;
  localparam int NV = 32;

  typedef struct packed {
    logic p, d, f; logic [3:0] req;
    logic e, r, l1, l2, w, rd, i, ds, h, lp;
    logic [3:0] st; logic [7:0] mode; logic up;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd0,8'h01,1'b0},
    '{1,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,1,0,4'h3,0,0,0,0,0,0,0,0,0,0,4'd2,8'h0A,1'b1},
    '{0,0,0,4'h0,0,0,0,0,0,0,1,0,0,0,4'd2,8'h0F,1'b1},
    '{0,0,0,4'h0,0,0,1,0,0,0,0,0,0,0,4'd3,8'h00,1'b1},
    '{0,0,0,4'h0,0,0,0,0,1,0,0,0,0,0,4'd5,8'h0A,1'b1},
    '{0,0,0,4'h0,0,0,0,0,0,1,0,0,0,0,4'd2,8'h0A,1'b1},
    '{0,0,0,4'h0,1,0,0,0,0,0,0,0,0,0,4'd5,8'h0A,1'b1},
    '{0,0,0,4'h0,0,0,0,0,0,1,0,0,0,0,4'd2,8'h0A,1'b1},
    '{0,0,0,4'h0,0,0,1,1,0,0,0,0,0,0,4'd4,8'h00,1'b0},
    '{0,0,0,4'h0,0,0,0,0,1,0,0,0,0,0,4'd0,8'h01,1'b0},
    '{1,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,1,1,4'h3,0,0,0,0,0,0,0,0,0,0,4'd0,8'h01,1'b0},
    '{1,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,1,0,4'hE,0,0,0,0,0,0,0,0,0,0,4'd2,8'hAA,1'b1},
    '{0,0,0,4'h0,0,1,1,0,0,0,0,0,0,0,4'd5,8'hAA,1'b1},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,1,1,4'd7,8'hAA,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,1,0,4'd7,8'hAA,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd0,8'h01,1'b0},
    '{1,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,1,4'd8,8'h02,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd0,8'h01,1'b0},
    '{1,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,1,1,0,4'd6,8'h00,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,1,0,0,4'd6,8'h00,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd0,8'h01,1'b0},
    '{1,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd1,8'h01,1'b0},
    '{0,1,0,4'h4,0,0,0,0,0,0,0,0,0,0,4'd2,8'h22,1'b1},
    '{0,0,0,4'h0,1,0,0,1,0,0,0,0,0,0,4'd5,8'h22,1'b1},
    '{0,0,0,4'h0,0,0,0,0,0,1,0,1,0,0,4'd6,8'h00,1'b0},
    '{0,0,0,4'h0,0,0,0,0,0,0,0,0,0,0,4'd0,8'h01,1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic peer, done, fail, err, rtr, l1, l2, wake, rdone, idle, dis, hot, lpb;
  logic [NL-1:0] req;
  logic [3:0] state;
  logic [2*NL-1:0] mode;
  logic up;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_train_ctrl #(.NUM_LANES(NL), .RECOV_TIMEOUT(RT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .peer_det_i(peer), .cfg_done_i(done),
    .cfg_fail_i(fail), .lane_req_i(req), .link_err_i(err), .retrain_i(rtr),
    .enter_l1_i(l1), .enter_l2_i(l2), .wake_i(wake), .recov_done_i(rdone),
    .tx_idle_i(idle), .dir_disable_i(dis), .dir_hot_reset_i(hot),
    .dir_loopback_i(lpb), .state_o(state), .lane_mode_o(mode), .link_up_o(up)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    peer = v.p; done = v.d; fail = v.f; req = v.req; err = v.e; rtr = v.r;
    l1 = v.l1; l2 = v.l2; wake = v.w; rdone = v.rd; idle = v.i;
    dis = v.ds; hot = v.h; lpb = v.lp;
  endtask

  task automatic quiet();
    vec_t z = '0;
    drive(z);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string tag, input logic [3:0] st,
                           input logic [7:0] md, input logic u);
    check({tag, " state"}, 32'(state), 32'(st));
    check({tag, " lane_mode"}, 32'(mode), 32'(md));
    check({tag, " link_up"}, 32'(up), 32'(u));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    quiet();
    #(CLK_PERIOD * 2 + 1);
    check_all("R1 in reset", 4'd0, 8'h01, 1'b0);
    rst_n = 1'b1;
    step();
    check_all("R1 after release", 4'd0, 8'h01, 1'b0);

    // table walk: R2..R10 transitions and lane decode
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      step();
      check_all($sformatf("R2-vec%0d R3 R4 R5 R6 R8 R9 R10", k),
                VECS[k].st, VECS[k].mode, VECS[k].up);
    end

    // R7: timeout after RT cycles in Recovery
    quiet(); peer = 1; step(); quiet();
    done = 1; req = 4'h1; step(); quiet();
    err = 1; step(); quiet();
    check_all("R7 enter", 4'd5, 8'h02, 1'b1);
    for (int k = 0; k < RT - 1; k++) step();
    check_all("R7 still recovering", 4'd5, 8'h02, 1'b1);
    step();
    check_all("R7 timeout to detect", 4'd0, 8'h01, 1'b0);

    // R7: done on the last cycle wins over the timeout
    peer = 1; step(); quiet();
    done = 1; req = 4'h8; step(); quiet();
    check_all("R4 mask 1001", 4'd2, 8'h82, 1'b1);
    rtr = 1; step(); quiet();
    for (int k = 0; k < RT - 1; k++) step();
    rdone = 1; step(); quiet();
    check_all("R7 done at limit", 4'd2, 8'h82, 1'b1);

    // R1: asynchronous reset from L0
    #(CLK_PERIOD / 2);
    rst_n = 1'b0;
    #1;
    check_all("R1 async reset", 4'd0, 8'h01, 1'b0);
    #(CLK_PERIOD);
    rst_n = 1'b1;
    step();
    check_all("R1 post reset idle", 4'd0, 8'h01, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule